// File: doc/BRIEF.md
# Serial-to-Parallel Nibble Converter

This block gathers a short burst of serial bits into a parallel word. While idle it watches a start strobe. Once the strobe is taken, it shifts in one bit from the serial input on each clock until a full word has arrived. It then raises a one-cycle completion pulse. The word width defaults to four bits. A bit counter tracks the position inside the frame, and a three-phase controller (waiting, shifting, full) sequences the work.

Bits arrive most significant first. The parallel output is the live content of the shift register, so during a capture it shows a mix of the previous word and the newly arrived bits. It is meaningful only while the completion pulse is high. After that, the word stays on the output until the next capture begins shifting. A start strobe given in the same cycle as the completion pulse opens the next frame at once, so frames can follow each other with no gap.

Top module: `nibble_deserializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `word_o` = 0 and `done_o` = 0. A frame cut short by reset produces no `done_o` pulse afterwards.
- R2: Bits are taken MSB first. The bit on `ser_i` in the first cycle after the start cycle ends in `word_o[WORD_W-1]`, and the last bit ends in `word_o[0]`.
- R3: `done_o` is high in exactly one cycle per frame. That cycle comes WORD_W+1 cycles after the cycle in which `start_i` was taken, and `word_o` then holds the captured word.
- R4: `start_i` asserted while a frame is being shifted has no effect. The frame's bits, its `done_o` cycle and its word are unchanged.
- R5: From the `done_o` cycle on, `word_o` keeps the captured value. It holds through idle cycles and through the cycle in which the next `start_i` is taken, and changes only at the first shift of the next frame.
- R6: `start_i` high during the `done_o` cycle begins a new frame. The next frame's first bit is taken in the following cycle, with no idle cycle between frames.
- R7: Without a taken `start_i`, `done_o` stays low and `ser_i` has no effect on `word_o`.
- R8: After j bits of a frame (1 <= j < WORD_W), `word_o` equals the previous word shifted left by j places, with the j new bits in the low j positions (MSB-first order), truncated to WORD_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Frame start strobe, taken while waiting or full |
| ser_i | input | 1 | Serial data bit, MSB first |
| word_o | output | WORD_W | Parallel word; valid while done_o is high |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the block with its default width of four. At that width all sixteen word values can be sent in every combination of two options: start held high during shifting or not, and back-to-back frames or an idle gap. Because the width is small, the intermediate word after each bit can be checked against an arithmetic shift of the previous word, which makes the partial-content rule visible at every step. Reset is applied both at rest and in the middle of a frame.

// File: rtl/s2p_pkg.sv
// Package: shared types for the serial-to-parallel converter.
// Assumes: the controller needs only three phases.
package s2p_pkg;

    // Controller phases: waiting for start, shifting bits in, word complete
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } s2p_state_e;

endpackage

// File: rtl/s2p_shift_reg.sv
// Module: s2p_shift_reg
// Shifts one serial bit into bit 0 on each enabled clock, so older bits
// move toward the MSB.
// Assumes: synchronous active-low reset clears every stage to zero.
module s2p_shift_reg #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              ser_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] stage_q;

    // Bit 0 takes the serial input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= 1'b0;
        end else if (shift_en_i) begin
            stage_q[0] <= ser_i;
        end
    end

    // Each higher stage takes its lower neighbour
    for (genvar i = 1; i < WORD_W; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[i] <= 1'b0;
            end else if (shift_en_i) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign word_o = stage_q;

endmodule

// File: rtl/s2p_bit_counter.sv
// Module: s2p_bit_counter
// Counts bit positions 0..WORD_W-1 inside a frame and flags the last one.
// Assumes: clear wins over advance; wraps to zero after the last position.
module s2p_bit_counter #(
    parameter int WORD_W = 4,
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] count_q;

    // Position register: clear on frame start, step on each shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (adv_i) begin
            count_q <= (count_q == LAST_POS) ? '0 : count_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign last_o  = (count_q == LAST_POS);

endmodule

// File: rtl/s2p_ctrl.sv
// Module: s2p_ctrl
// Three-phase controller: wait for start, shift until the last bit
// position, then signal completion for one cycle.
// Assumes: start is sampled only in the waiting and full phases.
module s2p_ctrl
    import s2p_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_i,
    output logic       shift_en_o,
    output logic       cnt_clr_o,
    output logic       done_o,
    output s2p_state_e state_o
);

    s2p_state_e state_q, state_d;

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (start_i) state_d = ST_SHIFT;
            ST_SHIFT: if (last_i)  state_d = ST_FULL;
            ST_FULL:  state_d = start_i ? ST_SHIFT : ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign shift_en_o = (state_q == ST_SHIFT);
    assign cnt_clr_o  = (state_q != ST_SHIFT) && start_i;
    assign done_o     = (state_q == ST_FULL);
    assign state_o    = state_q;

endmodule

// File: rtl/nibble_deserializer.sv
// Module: nibble_deserializer (top)
// Collects WORD_W serial bits, MSB first, into a parallel word under a
// start/done handshake.
// Assumes: one bit per clock while shifting; word_o valid while done_o high.
module nibble_deserializer
    import s2p_pkg::*;
#(
    parameter int WORD_W = 4,
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ser_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);

    logic             shift_en;
    logic             cnt_clr;
    logic             cnt_last;
    logic [CNT_W-1:0] cnt_val;
    s2p_state_e       ctrl_state;

    s2p_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .last_i     (cnt_last),
        .shift_en_o (shift_en),
        .cnt_clr_o  (cnt_clr),
        .done_o     (done_o),
        .state_o    (ctrl_state)
    );

    s2p_bit_counter #(.WORD_W(WORD_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .adv_i   (shift_en),
        .count_o (cnt_val),
        .last_o  (cnt_last)
    );

    s2p_shift_reg #(.WORD_W(WORD_W)) i_sreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .ser_i      (ser_i),
        .word_o     (word_o)
    );

endmodule

// File: rtl/s2p_chk.sv
// Module: s2p_chk
// Property checker bound to nibble_deserializer.
// Assumes: it observes the ports plus the controller phase and counter.
module s2p_chk
    import s2p_pkg::*;
#(
    parameter int WORD_W = 4,
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ser_i,
    input logic [WORD_W-1:0] word_o,
    input logic              done_o,
    input logic              shift_en,
    input logic              cnt_last,
    input logic [CNT_W-1:0]  cnt_val,
    input s2p_state_e        ctrl_state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (word_o == '0) && !done_o);

    // R2
    msb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[0] == $past(ser_i)));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && cnt_last) |=> done_o);

    // R4
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_SHIFT && !cnt_last) |=> (ctrl_state == ST_SHIFT));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o));

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (shift_en && cnt_val == '0));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_WAIT && !start_i) |=> !shift_en && !done_o);

endmodule

bind nibble_deserializer s2p_chk #(.WORD_W(WORD_W)) i_s2p_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ser_i      (ser_i),
    .word_o     (word_o),
    .done_o     (done_o),
    .shift_en   (shift_en),
    .cnt_last   (cnt_last),
    .cnt_val    (cnt_val),
    .ctrl_state (ctrl_state)
);

// File: tb/test_nibble_deserializer.sv
module test_nibble_deserializer;

    localparam int W = 4;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         ser_i = 1'b0;
    logic [W-1:0] word_o;
    logic         done_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] exp_word = '0;

    nibble_deserializer #(.WORD_W(W)) i_nibble_deserializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ser_i   (ser_i),
        .word_o  (word_o),
        .done_o  (done_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock; inputs set after this are seen at the next edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Sample outputs mid-cycle
    task automatic settle();
        #5;
    endtask

    // One frame: start cycle, then W bit cycles; ends in the done cycle
    task automatic send_frame(input logic [W-1:0] val, input bit start_busy);
        start_i = 1'b1;
        ser_i   = ~val[W-1];
        tick();
        settle();
        check(word_o == exp_word, "R5 word held over start", word_o, exp_word);
        check(done_o == 1'b0, "R3 no done at shift begin", done_o, 0);
        for (int j = 0; j < W; j++) begin
            start_i = start_busy;
            ser_i   = val[W-1-j];
            tick();
            settle();
            if (j < W - 1) begin
                logic [W-1:0] part;
                part = ((exp_word << (j + 1)) | (val >> (W - 1 - j))) & MASK;
                check(word_o == part, "R8 partial word", word_o, part);
                check(done_o == 1'b0, "R4 no early done", done_o, 0);
            end
        end
        start_i = 1'b0;
        check(done_o == 1'b1, "R3 done after last bit", done_o, 1);
        check(word_o == val, "R2 captured word MSB first", word_o, val);
        exp_word = val;
    endtask

    // Idle cycles with toggling serial data and no start
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            start_i = 1'b0;
            ser_i   = k[0];
            tick();
            settle();
            check(done_o == 1'b0, "R7 no done without start", done_o, 0);
            check(word_o == exp_word, "R7 word untouched while idle", word_o, exp_word);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset at rest with busy inputs
        rst_n = 1'b0; start_i = 1'b1; ser_i = 1'b1;
        repeat (3) tick();
        settle();
        check(word_o == '0, "R1 word cleared", word_o, 0);
        check(done_o == 1'b0, "R1 done low", done_o, 0);
        start_i = 1'b0;
        rst_n = 1'b1;
        idle(3);

        // Sweep: every value, start held or not, gap or back-to-back
        for (int mode = 0; mode < 4; mode++) begin
            for (int v = 0; v < (1 << W); v++) begin
                send_frame(W'(v), mode[0]);
                if (mode[1]) begin
                    // R6: next start rides on the done cycle
                    continue;
                end
                tick();
                settle();
                check(done_o == 1'b0, "R3 done one cycle only", done_o, 0);
                check(word_o == exp_word, "R5 word held after done", word_o, exp_word);
                idle(2);
            end
            tick();
            settle();
            check(done_o == 1'b0, "R6 done ends after chain", done_o, 0);
            check(word_o == exp_word, "R6 last chained word held", word_o, exp_word);
        end

        // R1: reset in the middle of a frame
        start_i = 1'b1; ser_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        settle();
        check(word_o == '0, "R1 mid-frame reset clears word", word_o, 0);
        exp_word = '0;
        for (int k = 0; k < W + 2; k++) begin
            ser_i = 1'b1;
            tick();
            settle();
            check(done_o == 1'b0, "R1 aborted frame gives no done", done_o, 0);
            check(word_o == '0, "R1 word stays clear", word_o, 0);
        end

        // R6: back-to-back pair after reset, then check data of both
        send_frame(W'(4'hA), 1'b0);
        send_frame(W'(4'h5), 1'b1);
        tick();
        settle();
        check(done_o == 1'b0, "R3 final done cleared", done_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule